// File: doc/BRIEF.md
# Audio Serial Clock Divider Chain

The block derives the three clocks of a serial audio link from one system clock. A master-clock divider and a bit-clock divider each count system clocks. A word-clock generator counts bit-clock periods. Each clock comes out twice: as a level signal and as a one-cycle rise pulse that logic running on the system clock can use as a clock enable. A divider field of zero selects the largest divide, 2^DIV_W, which is 1024 by default.

A source select picks how the bit and word clocks are produced. With controller mode set, the block generates them. With it clear, external bit and word clocks are resynchronised and passed through. In that mode the master clock stays low. The word clock can run in two ways. In dual-phase mode it is a square wave whose halves each span the programmed number of bit clocks. In single-phase mode it marks each frame with a one-bit-clock high pulse, and the frame is one bit clock shorter than the programmed value. An invert input flips the word-clock level. One enable gates the master clock and a second gates the bit/word pair; clearing an enable stops its clocks low and resets their counters.

Top module: `aud_clk_chain`

## Requirements
- R1: With controller mode set and the master enable high, mclk_o has a period of N system clocks and is high for floor(N/2) of them, where N is mclk_div_i, or 2^DIV_W when the field is 0 (legal N: 2 to 2^DIV_W).
- R2: With controller mode set and the bit/word enable high, bclk_o is derived from bclk_div_i by the same rule as R1.
- R3: Each rise pulse (mclk_rise_o, bclk_rise_o, wclk_rise_o) is one system clock wide and occurs once per period. For mclk and bclk it comes in the first high cycle of the level. For wclk it comes in the first cycle in which the non-inverted word level is high.
- R4: In dual-phase mode (dual_phase_i=1) the internal word clock is high for W bit-clock periods and low for W, where W is wclk_div_i (1 to 2^DIV_W-1). The word level changes only in the system clock that follows a bit-clock rise pulse.
- R5: In single-phase mode (dual_phase_i=0) a frame lasts W-1 bit-clock periods, and the word clock is high for exactly one bit-clock period of each frame (W at least 3).
- R6: wclk_inv_i=1 inverts wclk_o while the bit/word enable is high. It does not move wclk_rise_o.
- R7: With controller mode clear, bclk_o and wclk_o follow ext_bclk_i and ext_wclk_i delayed by two system clocks. The rise pulses mark their rising edges, and mclk_o and mclk_rise_o stay low.
- R8: When mclk_en_i is low, mclk_o and mclk_rise_o are low from the next cycle on. Re-enabling restarts the count, so the cycle after the enable is sampled shows mclk_o high with a rise pulse.
- R9: While bw_en_i is low, bclk_o, wclk_o and their pulses are low. On re-enable in controller mode, bclk_o rises the cycle after the enable is sampled, and wclk_o rises one cycle after that.
- R10: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_mode_i | input | 1 | 1: generate bit/word clocks, 0: pass external ones |
| mclk_en_i | input | 1 | Master clock enable |
| bw_en_i | input | 1 | Bit and word clock enable |
| dual_phase_i | input | 1 | Word clock phase mode |
| wclk_inv_i | input | 1 | Invert word clock level |
| mclk_div_i | input | DIV_W | Master clock divide (0 = 2^DIV_W) |
| bclk_div_i | input | DIV_W | Bit clock divide (0 = 2^DIV_W) |
| wclk_div_i | input | DIV_W | Word clock divide in bit clocks |
| ext_bclk_i | input | 1 | External bit clock |
| ext_wclk_i | input | 1 | External word clock |
| mclk_o | output | 1 | Master clock level |
| mclk_rise_o | output | 1 | Master clock rise pulse |
| bclk_o | output | 1 | Bit clock level |
| bclk_rise_o | output | 1 | Bit clock rise pulse |
| wclk_o | output | 1 | Word clock level |
| wclk_rise_o | output | 1 | Word clock start pulse |

## Verification
The assertions check on every cycle the relations that hold whatever the configuration. A rise pulse always sits on a high level, and no bit pulse repeats in back-to-back cycles. A cleared enable forces its outputs low. The internal word level moves only right after a bit pulse, and the master clock stays quiet in peripheral mode. The divide ratios, the duty-cycle rounding, the 0-means-maximum encoding, the single- versus dual-phase frame lengths, the inversion and the synchroniser latency depend on the programmed values. Only the bench's sweeps show these, by measuring periods and high times at the ports.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;
  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} clk_src_e;

  typedef struct packed {
    logic lvl;
    logic rise;
  } clk_t;
endpackage

// File: rtl/aud_clk_div.sv
module aud_clk_div
  import aud_clk_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output clk_t             clk_o
);
  localparam int CW = DIV_W + 1;
  localparam logic [CW-1:0] MAX_DIV = CW'(1) << DIV_W;

  logic [CW-1:0] n_eff, half, cnt;
  logic          run;

  assign n_eff = (div_i == '0) ? MAX_DIV : {1'b0, div_i};
  assign half  = n_eff >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!en_i) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (cnt >= n_eff - CW'(1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // odd divides: high phase is the shorter one
  assign clk_o.lvl  = run && (cnt < half);
  assign clk_o.rise = run && (cnt == '0);
endmodule

// File: rtl/aud_word_gen.sv
module aud_word_gen
  import aud_clk_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_rise_i,
  input  logic             dual_i,
  input  logic [DIV_W-1:0] div_i,
  output clk_t             clk_o
);
  logic [DIV_W-1:0] e_raw, e_eff, bcnt;
  logic             wrun, ph, rise_q, wrap;

  // single phase shortens the frame by one bit clock
  assign e_raw = dual_i ? div_i : div_i - DIV_W'(1);
  assign e_eff = (e_raw == '0) ? DIV_W'(1) : e_raw;
  assign wrap  = bcnt >= e_eff - DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrun   <= 1'b0;
      bcnt   <= '0;
      ph     <= 1'b0;
      rise_q <= 1'b0;
    end else if (!en_i) begin
      wrun   <= 1'b0;
      bcnt   <= '0;
      ph     <= 1'b0;
      rise_q <= 1'b0;
    end else if (bit_rise_i) begin
      rise_q <= !wrun || (wrap && (!dual_i || !ph));
      if (!wrun) begin
        wrun <= 1'b1;
        bcnt <= '0;
        ph   <= 1'b1;
      end else if (wrap) begin
        bcnt <= '0;
        ph   <= dual_i ? !ph : 1'b1;
      end else begin
        bcnt <= bcnt + DIV_W'(1);
        ph   <= dual_i ? ph : 1'b0;
      end
    end else begin
      rise_q <= 1'b0;
    end
  end

  assign clk_o.lvl  = wrun && ph;
  assign clk_o.rise = rise_q;
endmodule

// File: rtl/aud_edge_sync.sv
module aud_edge_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] lvl_o,
  output logic [LANES-1:0] rise_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DEPTH-1:0] sr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr <= '0;
      else         sr <= {sr[DEPTH-2:0], d_i[g]};
    end
    assign lvl_o[g]  = sr[STAGES-1];
    assign rise_o[g] = sr[STAGES-1] && !sr[STAGES];
  end
endmodule

// File: rtl/aud_clk_chain.sv
module aud_clk_chain
  import aud_clk_pkg::*;
#(
  parameter int DIV_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_mode_i,
  input  logic             mclk_en_i,
  input  logic             bw_en_i,
  input  logic             dual_phase_i,
  input  logic             wclk_inv_i,
  input  logic [DIV_W-1:0] mclk_div_i,
  input  logic [DIV_W-1:0] bclk_div_i,
  input  logic [DIV_W-1:0] wclk_div_i,
  input  logic             ext_bclk_i,
  input  logic             ext_wclk_i,
  output logic             mclk_o,
  output logic             mclk_rise_o,
  output logic             bclk_o,
  output logic             bclk_rise_o,
  output logic             wclk_o,
  output logic             wclk_rise_o
);
  clk_src_e src;
  clk_t     mclk_int, bclk_int, wclk_int, bclk_sel, wclk_sel;
  logic     int_bw_en;
  logic [1:0] ext_lvl, ext_rise;

  assign src       = clk_src_e'(ctrl_mode_i);
  assign int_bw_en = bw_en_i && (src == SRC_INT);

  aud_clk_div #(.DIV_W(DIV_W)) u_mclk_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (mclk_en_i && (src == SRC_INT)),
    .div_i (mclk_div_i),
    .clk_o (mclk_int)
  );

  aud_clk_div #(.DIV_W(DIV_W)) u_bclk_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (int_bw_en),
    .div_i (bclk_div_i),
    .clk_o (bclk_int)
  );

  aud_word_gen #(.DIV_W(DIV_W)) u_word_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (int_bw_en),
    .bit_rise_i(bclk_int.rise),
    .dual_i    (dual_phase_i),
    .div_i     (wclk_div_i),
    .clk_o     (wclk_int)
  );

  aud_edge_sync #(.LANES(2), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_wclk_i, ext_bclk_i}),
    .lvl_o (ext_lvl),
    .rise_o(ext_rise)
  );

  always_comb begin
    if (src == SRC_INT) begin
      bclk_sel = bclk_int;
      wclk_sel = wclk_int;
    end else begin
      bclk_sel = '{lvl: ext_lvl[0], rise: ext_rise[0]};
      wclk_sel = '{lvl: ext_lvl[1], rise: ext_rise[1]};
    end
  end

  assign mclk_o      = mclk_int.lvl;
  assign mclk_rise_o = mclk_int.rise;
  assign bclk_o      = bw_en_i && bclk_sel.lvl;
  assign bclk_rise_o = bw_en_i && bclk_sel.rise;
  assign wclk_o      = bw_en_i && (wclk_sel.lvl ^ wclk_inv_i);
  assign wclk_rise_o = bw_en_i && wclk_sel.rise;
endmodule

// File: rtl/aud_clk_chain_chk.sv
module aud_clk_chain_chk #(
  parameter int DIV_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_mode_i,
  input logic             mclk_en_i,
  input logic             bw_en_i,
  input logic             wclk_inv_i,
  input logic [DIV_W-1:0] bclk_div_i,
  input logic             mclk_o,
  input logic             mclk_rise_o,
  input logic             bclk_o,
  input logic             bclk_rise_o,
  input logic             wclk_o,
  input logic             wclk_rise_o
);
  a_r3_mclk_rise_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_rise_o |-> mclk_o);

  a_r3_bclk_rise_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_rise_o |-> bclk_o);

  a_r3_bclk_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclk_rise_o && bclk_div_i != DIV_W'(1)) |=> !bclk_rise_o);

  a_r6_wclk_rise_on_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wclk_rise_o |-> (wclk_o ^ wclk_inv_i));

  a_r8_mclk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclk_en_i |=> (!mclk_o && !mclk_rise_o));

  a_r7_mclk_quiet_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_mode_i |=> (!mclk_o && !mclk_rise_o));

  a_r9_bw_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bw_en_i |-> (!bclk_o && !wclk_o && !bclk_rise_o && !wclk_rise_o));

  a_r4_word_after_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_mode_i && $past(ctrl_mode_i) && bw_en_i && $past(bw_en_i)
     && !$past(bclk_rise_o) && $stable(wclk_inv_i)) |-> $stable(wclk_o));
endmodule

bind aud_clk_chain aud_clk_chain_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_mode_i(ctrl_mode_i),
  .mclk_en_i  (mclk_en_i),
  .bw_en_i    (bw_en_i),
  .wclk_inv_i (wclk_inv_i),
  .bclk_div_i (bclk_div_i),
  .mclk_o     (mclk_o),
  .mclk_rise_o(mclk_rise_o),
  .bclk_o     (bclk_o),
  .bclk_rise_o(bclk_rise_o),
  .wclk_o     (wclk_o),
  .wclk_rise_o(wclk_rise_o)
);

// File: tb/tb_aud_clk_chain.sv
module tb_aud_clk_chain;
  localparam int DIV_W = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ctrl_mode, mclk_en, bw_en, dual, inv, ext_b, ext_w;
  logic [DIV_W-1:0] mdiv, bdiv, wdiv;
  logic mclk, mrise, bclk, brise, wclk, wrise;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  aud_clk_chain #(.DIV_W(DIV_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_mode_i(ctrl_mode), .mclk_en_i(mclk_en),
    .bw_en_i(bw_en), .dual_phase_i(dual), .wclk_inv_i(inv),
    .mclk_div_i(mdiv), .bclk_div_i(bdiv), .wclk_div_i(wdiv),
    .ext_bclk_i(ext_b), .ext_wclk_i(ext_w),
    .mclk_o(mclk), .mclk_rise_o(mrise), .bclk_o(bclk), .bclk_rise_o(brise),
    .wclk_o(wclk), .wclk_rise_o(wrise)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic lvl(int s);
    return (s == 0) ? mclk : (s == 1) ? bclk : wclk;
  endfunction

  function automatic logic rs(int s);
    return (s == 0) ? mrise : (s == 1) ? brise : wrise;
  endfunction

  // one period from a rising level edge: high count, period, pulse count
  task automatic measure(int s, output int hi, output int per, output int np);
    int guard = 0;
    hi = 0; per = 0; np = 0;
    while (lvl(s) && guard < 5000) begin step(1); guard++; end
    while (!lvl(s) && guard < 5000) begin step(1); guard++; end
    while (lvl(s) && guard < 5000) begin
      hi++; per++; np += int'(rs(s)); step(1); guard++;
    end
    while (!lvl(s) && guard < 5000) begin
      per++; np += int'(rs(s)); step(1); guard++;
    end
  endtask

  task automatic restart();
    mclk_en = 1'b0; bw_en = 1'b0;
    step(2);
    mclk_en = 1'b1; bw_en = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int hi, per, np;
    ctrl_mode = 1'b1; mclk_en = 1'b1; bw_en = 1'b1; dual = 1'b1; inv = 1'b0;
    ext_b = 1'b0; ext_w = 1'b0; mdiv = 10'd4; bdiv = 10'd4; wdiv = 10'd2;
    step(3);
    // R10 reset state
    chk("R10 outputs in reset", {mclk, mrise, bclk, brise, wclk, wrise}, 0);
    rst_ni = 1'b1;
    step(1);

    // R1 master divider sweep, including the 0 encoding
    for (int d = 2; d <= 10; d++) begin
      int n;
      n = (d == 10) ? 1024 : d;
      mdiv = (d == 10) ? 10'd0 : DIV_W'(d);
      restart();
      measure(0, hi, per, np);
      chk($sformatf("R1 mclk period div=%0d", n), per, n);
      chk($sformatf("R1 mclk high div=%0d", n), hi, n / 2);
      chk($sformatf("R3 mclk pulses div=%0d", n), np, 1);
    end

    // R2 bit divider sweep
    for (int d = 2; d <= 9; d++) begin
      bdiv = DIV_W'(d);
      restart();
      measure(1, hi, per, np);
      chk($sformatf("R2 bclk period div=%0d", d), per, d);
      chk($sformatf("R2 bclk high div=%0d", d), hi, d / 2);
      chk($sformatf("R3 bclk pulses div=%0d", d), np, 1);
    end

    // R4 dual-phase word clock
    dual = 1'b1;
    for (int nb = 2; nb <= 3; nb++) begin
      for (int w = 1; w <= 5; w++) begin
        bdiv = DIV_W'(nb); wdiv = DIV_W'(w);
        restart();
        measure(2, hi, per, np);
        chk($sformatf("R4 dual period nb=%0d w=%0d", nb, w), per, 2 * nb * w);
        chk($sformatf("R4 dual high nb=%0d w=%0d", nb, w), hi, nb * w);
        chk($sformatf("R3 wclk pulses nb=%0d w=%0d", nb, w), np, 1);
      end
    end

    // R5 single-phase word clock
    dual = 1'b0;
    for (int nb = 2; nb <= 3; nb++) begin
      for (int w = 3; w <= 5; w++) begin
        bdiv = DIV_W'(nb); wdiv = DIV_W'(w);
        restart();
        measure(2, hi, per, np);
        chk($sformatf("R5 single period nb=%0d w=%0d", nb, w), per, nb * (w - 1));
        chk($sformatf("R5 single high nb=%0d w=%0d", nb, w), hi, nb);
      end
    end

    // R6 inversion in single phase
    inv = 1'b1; bdiv = 10'd3; wdiv = 10'd4;
    restart();
    measure(2, hi, per, np);
    chk("R6 inverted period", per, 9);
    chk("R6 inverted high", hi, 6);
    chk("R6 pulse count unchanged", np, 1);
    inv = 1'b0;

    // R9 restart timing and gating
    dual = 1'b1; bdiv = 10'd4; wdiv = 10'd2;
    bw_en = 1'b0;
    step(1);
    chk("R9 bclk low when disabled", bclk, 0);
    chk("R9 wclk low when disabled", wclk, 0);
    step(3);
    bw_en = 1'b1;
    step(1);
    chk("R9 bclk high after enable", {bclk, brise}, 3);
    chk("R9 wclk still low", wclk, 0);
    step(1);
    chk("R9 wclk rises next cycle", {wclk, wrise}, 3);

    // R8 master enable clear and restart
    mdiv = 10'd6;
    step(1);
    mclk_en = 1'b0;
    step(1);
    chk("R8 mclk low after clear", {mclk, mrise}, 0);
    step(5);
    chk("R8 mclk stays low", mclk, 0);
    mclk_en = 1'b1;
    step(1);
    chk("R8 mclk restarts high", {mclk, mrise}, 3);
    step(1);
    chk("R8 mclk pulse one cycle", {mclk, mrise}, 2);

    // R7 external source
    ctrl_mode = 1'b0; inv = 1'b1;
    step(3);
    chk("R7 mclk quiet in ext mode", mclk, 0);
    ext_b = 1'b1;
    step(1);
    chk("R7 bclk not yet through", bclk, 0);
    step(1);
    chk("R7 bclk after two cycles", {bclk, brise}, 3);
    step(1);
    chk("R7 bclk pulse ends", {bclk, brise}, 2);
    ext_b = 1'b0;
    step(2);
    chk("R7 bclk follows low", bclk, 0);
    chk("R6 ext wclk inverted idle", wclk, 1);
    ext_w = 1'b1;
    step(2);
    chk("R7 ext wclk inverted with pulse", {wclk, wrise}, 1);
    bw_en = 1'b0;
    step(1);
    chk("R9 ext clocks gated", {bclk, wclk, wrise}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule